// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the two doorbell interrupts that let the two sides of a shared memory notify each other. Each side, called left and right here, presents an active-low select, an active-low write strobe, an active-low read enable and an address. The two highest addresses of the address space are reserved as mailboxes. The very top address belongs to the right side and the one below it belongs to the left side.

Writing into the other side's mailbox raises that side's interrupt. The side that owns the mailbox lowers its interrupt again by reading its own mailbox. The data stored at those addresses is handled by the memory array, not by this block. Only the access strobes and addresses are observed, and the block assumes that neither side is stalled by arbitration during these accesses. All state is synchronous to one clock with an active-high synchronous reset. The address width is a parameter.

Top module: `mbx_intr`

## Requirements
- R1: While reset is high on a clock edge, both interrupt outputs are high (deasserted) after that edge.
- R2: The right mailbox is the all-ones address. The left mailbox is all ones with bit 0 cleared. No other address affects either interrupt.
- R3: A left write (sel_n=0, wr_n=0) to the right mailbox drives irq_r_n low after the next clock edge.
- R4: A right read (sel_n=0, rd_n=0, wr_n=1) of the right mailbox drives irq_r_n high after the next clock edge.
- R5: A right write to the left mailbox drives irq_l_n low after the next clock edge.
- R6: A left read of the left mailbox drives irq_l_n high after the next clock edge.
- R7: When a set and a clear of the same interrupt happen in the same cycle, the interrupt ends up asserted (low).
- R8: An access with sel_n=1, a read of the other side's mailbox, or a write to a side's own mailbox leaves both interrupts unchanged. Outside a set or clear, each interrupt keeps its value.
- R9: An access with wr_n=0 and rd_n=0 together counts as a write only and never as a read.
- R10: Each interrupt output is registered. It changes only on the clock edge that samples the qualifying access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_rd_n | input | 1 | Left read enable, active low |
| l_addr | input | ADDR_W | Left address |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_rd_n | input | 1 | Right read enable, active low |
| r_addr | input | ADDR_W | Right address |
| irq_l_n | output | 1 | Interrupt to the left side, active low |
| irq_r_n | output | 1 | Interrupt to the right side, active low |

## Verification
The functions that can meet in one cycle are the sender's write that raises an interrupt and the receiver's read that lowers the same interrupt. The bench sweeps every pairing of five access kinds and all sixteen addresses on each side of a 4-bit configuration. This drives the two sides at once, so the top address is written from the left while it is read from the right, and the same happens for the left mailbox. A reference model in the bench applies set-over-clear. The bench compares both outputs one edge after each access, so a wrong priority shows up as a high interrupt where the model expects it low.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      hit_own;
    logic      hit_peer;
  } acc_info_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter bit IS_RIGHT = 1'b0
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_info_t         info
);
  localparam logic [ADDR_W-1:0] TOP_SLOT  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_SLOT = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] OWN_SLOT  = IS_RIGHT ? TOP_SLOT : NEXT_SLOT;
  localparam logic [ADDR_W-1:0] PEER_SLOT = IS_RIGHT ? NEXT_SLOT : TOP_SLOT;

  always_comb begin
    if (sel_n)
      info.kind = ACC_IDLE;
    else if (!wr_n)
      info.kind = ACC_WRITE;   // a write strobe overrides a concurrent read enable
    else if (!rd_n)
      info.kind = ACC_READ;
    else
      info.kind = ACC_IDLE;
    info.hit_own  = (addr == OWN_SLOT);
    info.hit_peer = (addr == PEER_SLOT);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 1'b1;
    else if (set_req)
      irq_n <= 1'b0;
    else if (clr_req)
      irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbx_intr.sv
module mbx_intr
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel_n,
  input  logic              l_wr_n,
  input  logic              l_rd_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel_n,
  input  logic              r_wr_n,
  input  logic              r_rd_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              irq_l_n,
  output logic              irq_r_n
);
  localparam int NPORT = 2;  // index 0 = left, 1 = right

  logic [NPORT-1:0]              sel_n_v, wr_n_v, rd_n_v;
  logic [NPORT-1:0][ADDR_W-1:0]  addr_v;
  acc_info_t                     info_v [NPORT];
  logic [NPORT-1:0]              set_v, clr_v, irq_n_v;

  assign sel_n_v = {r_sel_n, l_sel_n};
  assign wr_n_v  = {r_wr_n,  l_wr_n};
  assign rd_n_v  = {r_rd_n,  l_rd_n};
  assign addr_v  = {r_addr,  l_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int PEER = NPORT - 1 - p;

    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .IS_RIGHT(p == 1)
    ) u_dec (
      .sel_n(sel_n_v[p]),
      .wr_n (wr_n_v[p]),
      .rd_n (rd_n_v[p]),
      .addr (addr_v[p]),
      .info (info_v[p])
    );

    // the peer raises this side's flag; this side clears its own
    assign set_v[p] = (info_v[PEER].kind == ACC_WRITE) && info_v[PEER].hit_peer;
    assign clr_v[p] = (info_v[p].kind == ACC_READ) && info_v[p].hit_own;

    mbx_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_req(set_v[p]),
      .clr_req(clr_v[p]),
      .irq_n  (irq_n_v[p])
    );
  end

  assign irq_l_n = irq_n_v[0];
  assign irq_r_n = irq_n_v[1];
endmodule

// File: rtl/mbx_intr_chk.sv
module mbx_intr_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              l_sel_n,
  input logic              l_wr_n,
  input logic              l_rd_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_sel_n,
  input logic              r_wr_n,
  input logic              r_rd_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              irq_l_n,
  input logic              irq_r_n
);
  localparam logic [ADDR_W-1:0] A_TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_NEXT = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_wr, l_rd, r_wr, r_rd, r_up, r_dn, l_up, l_dn;
  assign l_wr = !l_sel_n && !l_wr_n;
  assign r_wr = !r_sel_n && !r_wr_n;
  assign l_rd = !l_sel_n && !l_rd_n && l_wr_n;
  assign r_rd = !r_sel_n && !r_rd_n && r_wr_n;
  assign r_up = l_wr && (l_addr == A_TOP);
  assign r_dn = r_rd && (r_addr == A_TOP);
  assign l_up = r_wr && (r_addr == A_NEXT);
  assign l_dn = l_rd && (l_addr == A_NEXT);

  // R3 R7
  right_set_chk: assert property (@(posedge clk) disable iff (rst) r_up |=> !irq_r_n);
  // R4
  right_clr_chk: assert property (@(posedge clk) disable iff (rst) (r_dn && !r_up) |=> irq_r_n);
  // R5 R7
  left_set_chk: assert property (@(posedge clk) disable iff (rst) l_up |=> !irq_l_n);
  // R6
  left_clr_chk: assert property (@(posedge clk) disable iff (rst) (l_dn && !l_up) |=> irq_l_n);
  // R8
  right_hold_chk: assert property (@(posedge clk) disable iff (rst) !(r_up || r_dn) |=> $stable(irq_r_n));
  // R8
  left_hold_chk: assert property (@(posedge clk) disable iff (rst) !(l_up || l_dn) |=> $stable(irq_l_n));
  // R9
  both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (!r_sel_n && !r_wr_n && !r_rd_n && r_addr == A_TOP && !r_up && !irq_r_n) |=> !irq_r_n);
endmodule

bind mbx_intr mbx_intr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_rd_n(l_rd_n), .l_addr(l_addr),
  .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_rd_n(r_rd_n), .r_addr(r_addr),
  .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
);

// File: tb/mbx_intr_test.sv
module mbx_intr_test;
  localparam int AW = 4;
  localparam int TOP  = (1 << AW) - 1;
  localparam int NEXT = TOP - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel_n = 1'b1, l_wr_n = 1'b1, l_rd_n = 1'b1;
  logic r_sel_n = 1'b1, r_wr_n = 1'b1, r_rd_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic irq_l_n, irq_r_n;

  int errors = 0;
  int checks = 0;
  bit m_l = 1'b0, m_r = 1'b0;   // model: 1 = interrupt pending
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_intr #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_rd_n(l_rd_n), .l_addr(l_addr),
    .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_rd_n(r_rd_n), .r_addr(r_addr),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  // op: 0 idle, 1 read, 2 write, 3 write+read strobes, 4 deselected with strobes low
  function automatic logic [2:0] op_pins(input int op); // {sel_n, wr_n, rd_n}
    case (op)
      1: return 3'b010;
      2: return 3'b001;
      3: return 3'b000;
      4: return 3'b100;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int lop, input int la, input int rop, input int ra, input string tag);
    bit lw, lr, rw, rr, rs, rc, ls, lc;
    @(negedge clk);
    {l_sel_n, l_wr_n, l_rd_n} = op_pins(lop);
    {r_sel_n, r_wr_n, r_rd_n} = op_pins(rop);
    l_addr = la[AW-1:0];
    r_addr = ra[AW-1:0];
    lw = (lop == 2) || (lop == 3);
    rw = (rop == 2) || (rop == 3);
    lr = (lop == 1);
    rr = (rop == 1);
    rs = lw && la == TOP;  rc = rr && ra == TOP;
    ls = rw && ra == NEXT; lc = lr && la == NEXT;
    m_r = rs ? 1'b1 : (rc ? 1'b0 : m_r);
    m_l = ls ? 1'b1 : (lc ? 1'b0 : m_l);
    @(posedge clk);
    #1;
    check({tag, " right"}, irq_r_n, !m_r);
    check({tag, " left"},  irq_l_n, !m_l);
  endtask

  initial begin
    #(5 * 100000);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset right", irq_r_n, 1'b1);
    check("R1 reset left",  irq_l_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R3 R10: left write to top sets right interrupt one edge later
    @(negedge clk);
    {l_sel_n, l_wr_n, l_rd_n} = 3'b001; l_addr = TOP[AW-1:0];
    #1;
    check("R10 no change before edge", irq_r_n, 1'b1);
    @(posedge clk); #1;
    check("R3 right set", irq_r_n, 1'b0);
    m_r = 1'b1;
    step(0, 0, 1, NEXT, "R8 right reads peer mailbox");
    step(0, 0, 2, TOP,  "R8 right writes own mailbox");
    step(4, TOP, 4, TOP, "R8 deselected");
    step(0, 0, 3, TOP,  "R9 right both strobes");
    step(0, 0, 1, TOP,  "R4 right clear");
    step(0, 0, 2, NEXT, "R5 left set");
    step(1, TOP, 0, 0,  "R8 left reads peer mailbox");
    step(3, NEXT, 0, 0, "R9 left both strobes");
    step(1, NEXT, 0, 0, "R6 left clear");
    step(2, NEXT - 1, 0, 0, "R2 non mailbox");
    step(2, TOP, 1, TOP, "R7 right set and clear");
    step(1, NEXT, 2, NEXT, "R7 left set and clear");
    step(1, NEXT, 1, TOP, "R4 R6 both clear");

    // exhaustive sweep, R2 R3 R4 R5 R6 R7 R8 R9
    for (int lo = 0; lo < 5; lo++)
      for (int la = 0; la <= TOP; la++)
        for (int ro = 0; ro < 5; ro++)
          for (int ra = 0; ra <= TOP; ra++)
            step(lo, la, ro, ra, "R2-sweep R8");

    // reset mid-run with interrupts pending
    step(2, TOP, 2, NEXT, "R3 R5 before reset");
    @(negedge clk);
    rst = 1'b1;
    {l_sel_n, l_wr_n, l_rd_n} = 3'b111;
    {r_sel_n, r_wr_n, r_rd_n} = 3'b111;
    @(posedge clk); #1;
    check("R1 reset right", irq_r_n, 1'b1);
    check("R1 reset left",  irq_l_n, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule